// File: doc/BRIEF.md
# Serial Flash Command Front End

This block sits on the slave side of a serial flash device, between the four-wire serial bus and a memory-array model. It samples chip select, serial clock and serial input through a short synchronizer, collects an 8-bit opcode and a 3-byte address, and decides whether the opcode is one it serves. For a served command it raises a single-cycle command strobe with the opcode and a 22-bit address. It then fetches read bytes from the array over a parallel request port and shifts them out on the serial output.

Three opcodes are served, each set by a parameter: a plain read (03h), a read that drives two bits per clock (3Bh), and a status read that takes no address (05h). Any other opcode makes the block deaf until chip select goes inactive and then active again. A transfer that ends before its opcode and address are complete leaves no trace. The host must hold each serial clock level for at least three system clocks.

Top module: `spi_flash_front`

## Requirements
- R1: Once chip select (active low) is asserted, the first 8 rising serial-clock edges carry the opcode, MSB first. For an address command, cmdValid pulses for exactly one cycle after the 24th address bit, and cmdOpcode then holds the opcode.
- R2: The address arrives as 24 bits, MSB first. cmdAddr carries only the low 22 bits, so the two top received bits have no effect.
- R3: An opcode other than 03h, 3Bh or 05h produces no cmdValid and no rdReq, and both output enables stay low. Everything up to the next deassertion of chip select is ignored, and the next transfer is served normally.
- R4: If chip select is deasserted before the last address bit has been taken, nothing is issued. This includes a deassertion seen in the same cycle as that bit's rising edge. The next transfer is served normally.
- R5: Both serial clock idle levels are accepted: low (mode 0) and high (mode 3).
- R6: In a single-bit read (03h), data bytes appear on so MSB first. The value changes only after falling serial-clock edges, and the first bit appears after the first falling edge that follows the last address bit.
- R7: In a dual read (3Bh), siOe is high and each clock carries a bit pair: the more significant bit on siOut, the less significant on so. One byte takes 4 clocks.
- R8: rdReq pulses together with cmdValid, with rdAddr equal to cmdAddr. It pulses again each time a new byte starts shifting out, with the address one higher, and the address wraps from 3FFFFFh to 0.
- R9: The status read (05h) takes no address. cmdValid pulses after its 8th bit with address 0, and every data byte is requested from address 0.
- R10: soOe and siOe are low while chip select is inactive and during the opcode and address phases. siOe is high only in a dual read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| siOut | output | 1 | Upper bit of each pair in dual read, driven onto the input pin |
| siOe | output | 1 | Output enable for siOut |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for so |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdOpcode | output | 8 | Opcode of the issued command |
| cmdAddr | output | 22 | Masked address of the issued command |
| rdReq | output | 1 | Read byte request to the array |
| rdAddr | output | 22 | Address of the requested byte |
| rdData | input | 8 | Array byte for rdAddr, valid in the rdReq cycle |

## Verification
Command issue and abort can fall in the same cycle: the rising edge that completes the 24th address bit reaches the control in the same cycle as the deassertion of chip select. The bench provokes this by moving sck high and csN high in one time step. It judges the outcome by a cmdValid count and an rdReq count that do not change. A second overlap sits at the top of the array: a new byte's request can coincide with the address wrapping to zero. A dual read that starts at 3FFFFEh and runs past that point covers it, with the returned bytes compared against the model's data for the wrapped addresses.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic clear;      // chip select inactive: drop partial shift state
    logic shiftOp;    // take one opcode bit
    logic shiftAddr;  // take one address bit
    logic issueAddr;  // last address bit taken: issue command
    logic issueStat;  // last opcode bit of a no-address command
    logic take;       // falling edge starts a new output byte
    logic step;       // falling edge shifts the current output byte
    logic incr;       // next byte address increments
    logic dual;       // two bits per clock
  } strobe_t;

endpackage

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import spi_flash_pkg::*;
#(
  parameter int          ADDR_IN_W = 24,
  parameter logic [7:0]  RD_OP     = 8'h03,
  parameter logic [7:0]  DUAL_OP   = 8'h3B,
  parameter logic [7:0]  STAT_OP   = 8'h05
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csActive,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic [7:0] opNext,
  output strobe_t    stb,
  output logic       dataPhase,
  output logic       dualMode
);

  localparam int CNT_W = $clog2(ADDR_IN_W);
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_IN_W - 1);

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       outCnt;
  logic [2:0]       outCntWide;
  logic             statMode;
  logic             isRead, isDual, isStat, known;

  assign isRead = (opNext == RD_OP);
  assign isDual = (opNext == DUAL_OP);
  assign isStat = (opNext == STAT_OP);
  assign known  = isRead | isDual | isStat;

  assign dataPhase = (phase == PH_DATA);
  assign outCnt    = outCntWide[1:0];

  always_comb begin
    stb       = '0;
    stb.dual  = dualMode;
    stb.incr  = !statMode;
    if (!csActive) begin
      stb.clear = 1'b1;
    end else begin
      unique case (phase)
        PH_OPC: if (sckRise) begin
          stb.shiftOp = 1'b1;
          if (bitCnt == OP_LAST && isStat) stb.issueStat = 1'b1;
        end
        PH_ADDR: if (sckRise) begin
          stb.shiftAddr = 1'b1;
          if (bitCnt == ADDR_LAST) stb.issueAddr = 1'b1;
        end
        PH_DATA: if (sckFall) begin
          if (outCntWide == 3'd0) stb.take = 1'b1;
          else                    stb.step = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_OPC;
      bitCnt     <= '0;
      outCntWide <= '0;
      dualMode   <= 1'b0;
      statMode   <= 1'b0;
    end else if (!csActive) begin
      phase      <= PH_OPC;
      bitCnt     <= '0;
      outCntWide <= '0;
      dualMode   <= 1'b0;
      statMode   <= 1'b0;
    end else begin
      unique case (phase)
        PH_OPC: if (sckRise) begin
          if (bitCnt == OP_LAST) begin
            bitCnt   <= '0;
            dualMode <= isDual;
            statMode <= isStat;
            if (!known)      phase <= PH_SKIP;
            else if (isStat) phase <= PH_DATA;
            else             phase <= PH_ADDR;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_ADDR: if (sckRise) begin
          if (bitCnt == ADDR_LAST) begin
            bitCnt <= '0;
            phase  <= PH_DATA;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_DATA: if (sckFall) begin
          if (outCntWide == 3'd0) outCntWide <= dualMode ? 3'd3 : 3'd7;
          else                    outCntWide <= outCntWide - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // outCnt kept for width visibility of the dual counter range
  logic unusedLow;
  assign unusedLow = ^outCnt;

endmodule

// File: rtl/spi_flash_dpath.sv
module spi_flash_dpath
  import spi_flash_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              siBit,
  input  logic [7:0]        rdData,
  output logic [7:0]        opNext,
  output logic              cmdValid,
  output logic [7:0]        cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              soBit,
  output logic              siOutBit
);

  logic [7:0]        opShift;
  logic [ADDR_W-2:0] addrShift;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [7:0]        byteBuf;
  logic [7:0]        outShift;

  assign opNext   = {opShift[6:0], siBit};
  // only the low ADDR_W bits are kept: upper received bits fall off
  assign addrNext = {addrShift, siBit};
  assign nextAddr = stb.incr ? curAddr + 1'b1 : curAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opShift   <= '0;
      addrShift <= '0;
      curAddr   <= '0;
      byteBuf   <= '0;
      outShift  <= '0;
      cmdValid  <= 1'b0;
      cmdOpcode <= '0;
      cmdAddr   <= '0;
      rdReq     <= 1'b0;
      rdAddr    <= '0;
      soBit     <= 1'b0;
      siOutBit  <= 1'b0;
    end else begin
      cmdValid <= 1'b0;
      rdReq    <= 1'b0;
      if (rdReq) byteBuf <= rdData;
      if (stb.clear) begin
        opShift   <= '0;
        addrShift <= '0;
      end
      if (stb.shiftOp)   opShift   <= opNext;
      if (stb.shiftAddr) addrShift <= addrNext[ADDR_W-2:0];
      if (stb.issueAddr) begin
        cmdValid  <= 1'b1;
        cmdOpcode <= opShift;
        cmdAddr   <= addrNext;
        curAddr   <= addrNext;
        rdReq     <= 1'b1;
        rdAddr    <= addrNext;
      end
      if (stb.issueStat) begin
        cmdValid  <= 1'b1;
        cmdOpcode <= opNext;
        cmdAddr   <= '0;
        curAddr   <= '0;
        rdReq     <= 1'b1;
        rdAddr    <= '0;
      end
      if (stb.take) begin
        rdReq   <= 1'b1;
        rdAddr  <= nextAddr;
        curAddr <= nextAddr;
        if (stb.dual) begin
          siOutBit <= byteBuf[7];
          soBit    <= byteBuf[6];
          outShift <= {byteBuf[5:0], 2'b00};
        end else begin
          soBit    <= byteBuf[7];
          outShift <= {byteBuf[6:0], 1'b0};
        end
      end
      if (stb.step) begin
        if (stb.dual) begin
          siOutBit <= outShift[7];
          soBit    <= outShift[6];
          outShift <= {outShift[5:0], 2'b00};
        end else begin
          soBit    <= outShift[7];
          outShift <= {outShift[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import spi_flash_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_IN_W   = 24,
  parameter int         ADDR_W      = 22,
  parameter logic [7:0] RD_OP       = 8'h03,
  parameter logic [7:0] DUAL_OP     = 8'h3B,
  parameter logic [7:0] STAT_OP     = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  output logic              siOut,
  output logic              siOe,
  output logic              so,
  output logic              soOe,
  output logic              cmdValid,
  output logic [7:0]        cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData
);

  // {csN, sck, si} through SYNC_STAGES registers
  logic [2:0] syncChain [SYNC_STAGES+1];
  assign syncChain[0] = {csN, sck, si};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[g+1] <= 3'b100;
      else       syncChain[g+1] <= syncChain[g];
    end
  end

  logic csS, sckS, siS, sckPrev;
  logic csActive, sckRise, sckFall;
  assign {csS, sckS, siS} = syncChain[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign csActive = !csS;
  assign sckRise  = csActive &&  sckS && !sckPrev;
  assign sckFall  = csActive && !sckS &&  sckPrev;

  strobe_t    stb;
  logic [7:0] opNext;
  logic       dataPhase, dualMode;

  spi_flash_ctrl #(
    .ADDR_IN_W (ADDR_IN_W),
    .RD_OP     (RD_OP),
    .DUAL_OP   (DUAL_OP),
    .STAT_OP   (STAT_OP)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csActive  (csActive),
    .sckRise   (sckRise),
    .sckFall   (sckFall),
    .opNext    (opNext),
    .stb       (stb),
    .dataPhase (dataPhase),
    .dualMode  (dualMode)
  );

  spi_flash_dpath #(
    .ADDR_W (ADDR_W)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .siBit     (siS),
    .rdData    (rdData),
    .opNext    (opNext),
    .cmdValid  (cmdValid),
    .cmdOpcode (cmdOpcode),
    .cmdAddr   (cmdAddr),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .soBit     (so),
    .siOutBit  (siOut)
  );

  assign soOe = dataPhase && csActive;
  assign siOe = soOe && dualMode;

endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk #(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 22,
  parameter logic [7:0] STAT_OP     = 8'h05
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sckS,
  input logic              so,
  input logic              soOe,
  input logic              siOe,
  input logic              cmdValid,
  input logic [7:0]        cmdOpcode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr
);

  int unsigned csHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     csHigh <= 0;
    else if (!csN)                 csHigh <= 0;
    else if (csHigh <= SYNC_STAGES) csHigh <= csHigh + 1;
  end

  // R10
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csHigh > SYNC_STAGES) |-> (!soOe && !siOe));

  // R7
  dual_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    siOe |-> soOe);

  // R1
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R8
  first_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (rdReq && rdAddr == cmdAddr));

  // R9
  stat_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == STAT_OP) |-> (cmdAddr == '0));

  // R6
  so_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (soOe && $past(soOe) && !$stable(so)) |-> ($past(sckS, 2) && !$past(sckS)));

endmodule

bind spi_flash_front spi_flash_front_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .ADDR_W      (ADDR_W),
  .STAT_OP     (STAT_OP)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .sckS      (sckS),
  .so        (so),
  .soOe      (soOe),
  .siOe      (siOe),
  .cmdValid  (cmdValid),
  .cmdOpcode (cmdOpcode),
  .cmdAddr   (cmdAddr),
  .rdReq     (rdReq),
  .rdAddr    (rdAddr)
);

// File: tb/test_spi_flash_front.sv
module test_spi_flash_front;

  localparam int H = 6;
  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_DUAL = 8'h3B;
  localparam logic [7:0] OP_STAT = 8'h05;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic        siOut, siOe, so, soOe, cmdValid, rdReq;
  logic [7:0]  cmdOpcode, rdData;
  logic [21:0] cmdAddr, rdAddr;

  always #5 clk = ~clk;

  spi_flash_front i_spi_flash_front (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .siOut(siOut), .siOe(siOe), .so(so), .soOe(soOe),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [7:0] dataOf(logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b00} ^ 8'h5A;
  endfunction

  assign rdData = dataOf(rdAddr);

  int checks = 0, errors = 0;
  int cmdCnt = 0, reqCnt = 0, oeBad = 0;
  logic [7:0]  lastOp = '0;
  logic [21:0] lastAddr = '0, lastReq = '0;
  bit watchOe = 1'b0;

  always @(posedge clk) begin
    if (rstN) begin
      if (cmdValid) begin
        cmdCnt   <= cmdCnt + 1;
        lastOp   <= cmdOpcode;
        lastAddr <= cmdAddr;
      end
      if (rdReq) begin
        reqCnt  <= reqCnt + 1;
        lastReq <= rdAddr;
      end
      if (watchOe && (soOe || siOe)) oeBad <= oeBad + 1;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitC(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startXfer(bit mode3);
    sck = mode3;
    waitC(H);
    csN = 1'b0;
    waitC(H);
  endtask

  task automatic endXfer(bit mode3);
    sck = mode3;
    waitC(H);
    csN = 1'b1;
    waitC(2 * H);
  endtask

  task automatic sendBits(logic [7:0] b, int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      sck = 1'b0; si = b[i];
      waitC(H);
      sck = 1'b1;
      waitC(H);
    end
  endtask

  task automatic readByte(bit dual, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < (dual ? 4 : 8); i++) begin
      sck = 1'b0;
      waitC(H);
      if (dual) v = {v[5:0], siOut, so};
      else      v = {v[6:0], so};
      sck = 1'b1;
      waitC(H);
    end
  endtask

  // full read transaction with checks against the requirements
  task automatic doRead(bit mode3, logic [7:0] op, logic [23:0] a24, int n);
    int c0, r0, extra;
    bit stat, dual;
    logic [21:0] base, expA;
    logic [7:0] v;
    stat = (op == OP_STAT);
    dual = (op == OP_DUAL);
    base = stat ? 22'd0 : a24[21:0];
    c0 = cmdCnt; r0 = reqCnt;
    startXfer(mode3);
    if (!stat) begin
      watchOe = 1'b1;
      sendBits(op, 8);
      sendBits(a24[23:16], 8);
      sendBits(a24[15:8], 8);
      watchOe = 1'b0;
      check(oeBad == 0, "R10", "oe during opcode/address", oeBad, 0);
      sendBits(a24[7:0], 8);
    end else begin
      sendBits(op, 8);
    end
    check(cmdCnt == c0 + 1, stat ? "R9" : "R1", "cmd count", cmdCnt - c0, 1);
    check(lastOp == op, "R1", "opcode", lastOp, op);
    check(lastAddr == base, stat ? "R9" : "R2", "masked address", lastAddr, base);
    check(soOe == 1'b1, "R10", "soOe in data", soOe, 1);
    check(siOe == dual, "R7", "siOe", siOe, dual);
    for (int i = 0; i < n; i++) begin
      expA = stat ? 22'd0 : base + 22'(i);
      readByte(dual, v);
      check(v == dataOf(expA), dual ? "R7" : (stat ? "R9" : "R6"),
            "data byte", v, dataOf(expA));
    end
    endXfer(mode3);
    extra = mode3 ? 0 : 1;
    expA = stat ? 22'd0 : base + 22'(n + extra);
    check(reqCnt - r0 == n + 1 + extra, "R8", "request count", reqCnt - r0, n + 1 + extra);
    check(lastReq == expA, stat ? "R9" : "R8", "last request address", lastReq, expA);
    check(!soOe && !siOe, "R10", "oe after deselect", {soOe, siOe}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    waitC(4);
    check(!soOe && !siOe && !cmdValid && !rdReq, "R10", "reset outputs",
          {soOe, siOe, cmdValid, rdReq}, 0);
    rstN = 1'b1;
    waitC(4);

    // R1 R2 R6 R5: mode 0 single read, top address bits set
    doRead(1'b0, OP_RD, 24'hC12345, 3);
    // R7 R8 R5: mode 3 dual read across the wrap point
    doRead(1'b1, OP_DUAL, 24'h3FFFFE, 4);
    // R9: status read in both modes
    doRead(1'b1, OP_STAT, 24'h0, 2);
    doRead(1'b0, OP_STAT, 24'h0, 1);

    // R3: unsupported opcode followed by traffic that looks like a read
    begin
      int c0, r0;
      c0 = cmdCnt; r0 = reqCnt;
      startXfer(1'b0);
      watchOe = 1'b1;
      sendBits(8'hA7, 8);
      sendBits(OP_RD, 8);
      sendBits(8'h00, 8);
      sendBits(8'h10, 8);
      sendBits(8'h20, 8);
      sendBits(8'hFF, 8);
      endXfer(1'b0);
      watchOe = 1'b0;
      check(cmdCnt == c0, "R3", "cmd after unsupported", cmdCnt - c0, 0);
      check(reqCnt == r0, "R3", "req after unsupported", reqCnt - r0, 0);
      check(oeBad == 0, "R3", "oe after unsupported", oeBad, 0);
    end
    doRead(1'b0, OP_RD, 24'h000100, 1);

    // R4: abort in the middle of the address
    begin
      int c0, r0;
      c0 = cmdCnt; r0 = reqCnt;
      startXfer(1'b1);
      sendBits(OP_RD, 8);
      sendBits(8'h12, 8);
      sendBits(8'h34, 4);
      endXfer(1'b1);
      check(cmdCnt == c0, "R4", "cmd after abort", cmdCnt - c0, 0);
      check(reqCnt == r0, "R4", "req after abort", reqCnt - r0, 0);
    end
    doRead(1'b1, OP_RD, 24'h123456, 2);

    // R4: deselect in the same step as the last address rising edge
    begin
      int c0, r0;
      c0 = cmdCnt; r0 = reqCnt;
      startXfer(1'b0);
      sendBits(OP_RD, 8);
      sendBits(8'h00, 8);
      sendBits(8'h00, 8);
      sendBits(8'h00, 7);
      sck = 1'b0; si = 1'b1;
      waitC(H);
      sck = 1'b1; csN = 1'b1;
      waitC(H);
      sck = 1'b0;
      waitC(2 * H);
      check(cmdCnt == c0, "R4", "cmd on coincident deselect", cmdCnt - c0, 0);
      check(reqCnt == r0, "R4", "req on coincident deselect", reqCnt - r0, 0);
      check(!soOe, "R10", "soOe after coincident deselect", soOe, 0);
    end

    // random mix, R5 across modes
    for (int k = 0; k < 8; k++) begin
      bit m3;
      logic [7:0] op;
      int pick;
      m3 = 1'($urandom % 2);
      pick = $urandom % 3;
      op = (pick == 0) ? OP_RD : (pick == 1) ? OP_DUAL : OP_STAT;
      doRead(m3, op, 24'($urandom), 1 + $urandom % 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule